// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Programmable Flags

This block is a first-in first-out buffer for 18-bit words. Its write side and its read side each run on their own free-running clock, and the two clocks may be unrelated or connected to the same source. Each side has an enable. A write enable stores one word per write-clock edge unless the buffer is full. A read enable presents the oldest word at the output on the read-clock edge that takes it, unless the buffer is empty.

Besides Empty and Full, the block gives three occupancy flags: Half-Full, Almost-Full and Almost-Empty. The almost thresholds are margins held in two offset registers. Software or a controller loads them at run time over the same input bus that carries data: while the load input is high, each write-enabled edge sends the bus word to an offset register instead of into the buffer, and a two-state selector decides which register receives it. The pointers cross between the clock domains in Gray code through two-stage synchronizers. Each flag is therefore computed from a slightly stale view of the other side, and that view always errs toward "fuller" on the write side and toward "emptier" on the read side.

Top module: `dc_fifo_pflag`

## Requirements
- R1: Words come out in the order they were accepted. `rdata_o` takes the next word on the read-clock edge that performs the read and holds it until the next read.
- R2: A word is accepted on a write-clock rising edge only when `wr_en_i` is high, `load_i` is low and `full_o` is low. A write attempted while full is dropped and never reaches the output.
- R3: A read happens on a read-clock rising edge only when `rd_en_i` is high and `empty_o` is low. A read attempted while empty leaves `rdata_o` and the occupancy unchanged.
- R4: After the active-low asynchronous reset, `empty_o`=1, `almost_empty_o`=1, `full_o`=0, `half_full_o`=0, `almost_full_o`=0 and `rdata_o`=0, and both offset registers hold 7.
- R5: `full_o` is 1 exactly when the occupancy seen in the write domain equals DEPTH. It is evaluated from write-clock registers.
- R6: `empty_o` is 1 exactly when the occupancy seen in the read domain is 0. It is evaluated from read-clock registers and falls no later than the third read-clock edge after the write edge.
- R7: `almost_full_o` is 1 when occupancy >= DEPTH - F, where F is the full offset.
- R8: `almost_empty_o` is 1 when occupancy <= E, where E is the empty offset.
- R9: `half_full_o` is 1 when occupancy > DEPTH/2.
- R10: While `load_i` is high, each write-enabled edge stores `wdata_i` into an offset register and not into the buffer. The first such edge loads E, the second loads F, and the third loads E again, alternating from there. Whenever `load_i` is low, the selector returns to E.
- R11: Pointers cross domains as Gray code through two flops. The true occupancy never exceeds DEPTH, and the write pointer advances by at most one per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wr_en_i | input | 1 | Write enable |
| load_i | input | 1 | Steers write-enabled words to the offset registers |
| wdata_i | input | DW | Data or offset word |
| rd_en_i | input | 1 | Read enable |
| rdata_o | output | DW | Word last read |
| empty_o | output | 1 | Buffer empty (read domain) |
| almost_empty_o | output | 1 | Occupancy at or below E (read domain) |
| half_full_o | output | 1 | Occupancy above half (write domain) |
| almost_full_o | output | 1 | Occupancy at or above DEPTH-F (write domain) |
| full_o | output | 1 | Buffer full (write domain) |

## Verification
The assertions watch four properties on every edge: that no write gets in while full or while loading, that no read moves the pointer or the data while empty, that Full implies the two weaker write-side flags, and that the real occupancy stays bounded with the pointer moving in unit steps. The exact flag thresholds, the data order, and the behaviour of the offset selector (including its wrap and its restart when load drops) can only be shown by the bench. It fills and drains the buffer one word at a time and checks every flag at every occupancy, under several offset pairs that it loads through the bus.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} off_sel_e;
endpackage

// File: rtl/fifo_pf_sync.sv
`timescale 1ns/1ps
module fifo_pf_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fifo_pf_ram.sv
`timescale 1ns/1ps
module fifo_pf_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fifo_pf_wr.sv
`timescale 1ns/1ps
module fifo_pf_wr
  import fifo_pf_pkg::*;
#(
  parameter int DW      = 18,
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] wgray_o,
  output logic          push_o,
  output logic [DW-1:0] eoff_o,
  output logic          full_o,
  output logic          almost_full_o,
  output logic          half_full_o
);
  logic [PW-1:0] rbin_s, wcnt, wnext;
  logic [DW-1:0] foff_q;
  off_sel_e      sel_q;

  always_comb begin
    rbin_s[PW-1] = rgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_sync_i[i];
  end

  assign wcnt          = wptr_o - rbin_s;
  assign full_o        = (wcnt == PW'(DEPTH));
  assign half_full_o   = (wcnt > PW'(DEPTH / 2));
  assign almost_full_o = (int'(wcnt) + int'(foff_q)) >= DEPTH;
  assign push_o        = wr_en_i && !load_i && !full_o;
  assign wnext         = wptr_o + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_o  <= '0;
      wgray_o <= '0;
    end else if (push_o) begin
      wptr_o  <= wnext;
      wgray_o <= wnext ^ (wnext >> 1);
    end
  end

  // offset selector: restarts at the empty offset whenever load is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoff_o <= DW'(DEF_OFF);
      foff_q <= DW'(DEF_OFF);
      sel_q  <= SEL_EMPTY;
    end else if (!load_i) begin
      sel_q <= SEL_EMPTY;
    end else if (wr_en_i) begin
      if (sel_q == SEL_EMPTY) begin
        eoff_o <= wdata_i;
        sel_q  <= SEL_FULL;
      end else begin
        foff_q <= wdata_i;
        sel_q  <= SEL_EMPTY;
      end
    end
  end
endmodule

// File: rtl/fifo_pf_rd.sv
`timescale 1ns/1ps
module fifo_pf_rd #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wgray_sync_i,
  input  logic [DW-1:0] eoff_i,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] rgray_o,
  output logic          pop_o,
  output logic          empty_o,
  output logic          almost_empty_o
);
  logic [PW-1:0] wbin_s, rcnt, rnext;

  always_comb begin
    wbin_s[PW-1] = wgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_sync_i[i];
  end

  assign rcnt           = wbin_s - rptr_o;
  assign empty_o        = (rcnt == '0);
  assign almost_empty_o = int'(rcnt) <= int'(eoff_i);
  assign pop_o          = rd_en_i && !empty_o;
  assign rnext          = rptr_o + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_o  <= '0;
      rgray_o <= '0;
    end else if (pop_o) begin
      rptr_o  <= rnext;
      rgray_o <= rnext ^ (rnext >> 1);
    end
  end
endmodule

// File: rtl/dc_fifo_pflag.sv
`timescale 1ns/1ps
module dc_fifo_pflag #(
  parameter int DW      = 18,
  parameter int DEPTH   = 256,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          almost_empty_o,
  output logic          half_full_o,
  output logic          almost_full_o,
  output logic          full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] w_ptr, r_ptr, w_gray, r_gray, w_gray_rs, r_gray_ws;
  logic [DW-1:0] eoff;
  logic          push, pop;

  fifo_pf_wr #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .load_i(load_i),
    .wdata_i(wdata_i), .rgray_sync_i(r_gray_ws), .wptr_o(w_ptr), .wgray_o(w_gray),
    .push_o(push), .eoff_o(eoff), .full_o(full_o), .almost_full_o(almost_full_o),
    .half_full_o(half_full_o)
  );

  fifo_pf_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wgray_sync_i(w_gray_rs),
    .eoff_i(eoff), .rptr_o(r_ptr), .rgray_o(r_gray), .pop_o(pop),
    .empty_o(empty_o), .almost_empty_o(almost_empty_o)
  );

  fifo_pf_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(w_gray), .q_o(w_gray_rs));
  fifo_pf_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(r_gray), .q_o(r_gray_ws));

  fifo_pf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
    .we_i(push), .waddr_i(w_ptr[AW-1:0]), .wdata_i(wdata_i),
    .re_i(pop), .raddr_i(r_ptr[AW-1:0]), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/dc_fifo_pflag_chk.sv
`timescale 1ns/1ps
module dc_fifo_pflag_chk #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          load_i,
  input logic          full_o,
  input logic          empty_o,
  input logic          almost_full_o,
  input logic          half_full_o,
  input logic [DW-1:0] rdata_o,
  input logic [PW-1:0] w_ptr,
  input logic [PW-1:0] r_ptr
);
  // R2
  no_push_when_full_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && wr_en_i |=> w_ptr == $past(w_ptr));

  // R10
  load_no_push_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    load_i |=> w_ptr == $past(w_ptr));

  // R3
  no_pop_when_empty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |=> (r_ptr == $past(r_ptr)) && $stable(rdata_o));

  // R5
  full_implies_flags_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o && half_full_o);

  // R11
  occupancy_bound_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (w_ptr - r_ptr) <= PW'(DEPTH));

  // R11
  wptr_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> (w_ptr == $past(w_ptr)) || (w_ptr == $past(w_ptr) + PW'(1)));
endmodule

bind dc_fifo_pflag dc_fifo_pflag_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .load_i(load_i), .full_o(full_o), .empty_o(empty_o),
  .almost_full_o(almost_full_o), .half_full_o(half_full_o),
  .rdata_o(rdata_o), .w_ptr(w_ptr), .r_ptr(r_ptr)
);

// File: tb/dc_fifo_pflag_tb.sv
`timescale 1ns/1ps
module dc_fifo_pflag_tb;
  localparam int DW    = 18;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, wr_en, load, rd_en;
  logic [DW-1:0] wdata, rdata;
  logic empty, ae, hf, af, full;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  dc_fifo_pflag #(.DW(DW), .DEPTH(DEPTH), .DEF_OFF(7)) u_dut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .load_i(load),
    .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata), .empty_o(empty),
    .almost_empty_o(ae), .half_full_o(hf), .almost_full_o(af), .full_o(full)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_flags(input int c, input int e, input int f);
    chk("R6 empty",        int'(empty), int'(c == 0));
    chk("R5 full",         int'(full),  int'(c == DEPTH));
    chk("R8 almost_empty", int'(ae),    int'(c <= e));
    chk("R7 almost_full",  int'(af),    int'(c >= DEPTH - f));
    chk("R9 half_full",    int'(hf),    int'(c > DEPTH / 2));
  endtask

  function automatic logic [DW-1:0] pat(input int base, input int i);
    return DW'(base * 4099 + i * 37 + 5);
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop_expect(input string tag, input logic [DW-1:0] exp);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, int'(rdata), int'(exp));
  endtask

  task automatic load_word(input logic [DW-1:0] d);
    @(negedge clk); load = 1'b1; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic load_end();
    @(negedge clk); load = 1'b0;
  endtask

  // fill to full, overrun, drain, underrun; flags checked at every occupancy
  task automatic sweep(input int base, input int e, input int f);
    settle();
    check_flags(0, e, f);
    for (int i = 1; i <= DEPTH; i++) begin
      push(pat(base, i));
      settle();
      check_flags(i, e, f);
    end
    push('1); // R2: dropped while full
    settle();
    check_flags(DEPTH, e, f);
    for (int i = 1; i <= DEPTH; i++) begin
      pop_expect("R1 order", pat(base, i));
      settle();
      check_flags(DEPTH - i, e, f);
    end
    pop_expect("R3 read while empty", pat(base, DEPTH));
    settle();
    check_flags(0, e, f);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; load = 1'b0; rd_en = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    check_flags(0, 7, 7);
    chk("R4 rdata reset", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    sweep(1, 7, 7);                    // R4 default offsets
    load_word(2); load_word(3); load_end();
    sweep(2, 2, 3);                    // R10 first E then F
    load_word(5); load_word(4); load_word(1); load_end();
    sweep(3, 1, 4);                    // R10 wrap back to E
    load_word(6); load_end(); load_word(2); load_end();
    sweep(4, 2, 4);                    // R10 selector restarts when load low
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule